// File: doc/BRIEF.md
# Board Interrupt Aggregator and Status Register Bank

This block gathers a bank of external interrupt request lines into a single interrupt line toward a processor. Software owns two registers that decide what reaches that line. The enable register selects which lines may raise a request. The pending register records the requests that have been raised. A pending bit is latched only when its line rises while its enable bit is already set. The bit then stays set until software rewrites the pending register. The outgoing interrupt is a registered OR over the pending bits that are also enabled.

Two of the interrupt lines also report card presence for two card sockets. Each socket has a status word. An active-low card-absent bit in that word follows its line, a ready bit is fixed at reset, and only a small control field is writable. Eight further words are plain 32-bit scratch storage for board status and control. All registers sit on a simple synchronous bus with byte offsets and one-cycle registered read data. Unmapped offsets read as zero and ignore writes.

Top module: `irq_board_ctrl`

## Requirements
- R1: While `rst_n` is low the enable, pending and scratch registers clear to 0 and `irq_out` is 0. Both socket words (offset 0xE0 for socket 0, 0xE4 for socket 1) reset to 0x0000_0420: bit 10 is ready and bit 5 is card-absent.
- R2: The scratch words at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 each read back the full 32-bit value last written to them.
- R3: A read of any offset not listed in R2, R4 or R1 returns 0, and a write to such an offset changes no register.
- R4: Writes to the enable register (offset 0xC0) and the pending register (offset 0xD0) store the data ANDed with 0x000F_EEFF. Bits 8, 12 and 31:20 therefore always read 0.
- R5: Pending bit i sets on the clock edge after `irq_in[i]` goes from 0 to 1, but only if enable bit i is 1 at that edge. A rise that happens while the bit is disabled never sets it, even if the enable bit is set later while the line stays high.
- R6: A pending bit stays set when its input falls. Only a write to the pending register changes it.
- R7: `irq_out` equals the OR of (pending AND enable) as it stood one clock earlier. A register write therefore shows at `irq_out` one cycle after the write edge.
- R8: When a pending-register write and an input rise fall on the same edge, the pending register takes exactly the filtered write data.
- R9: Bit 5 of the socket-0 word holds the inverse of `irq_in[9]`, and bit 5 of the socket-1 word holds the inverse of `irq_in[13]`, each as sampled at the previous clock edge.
- R10: A write to a socket word changes only its bits 4:0. Bit 10 stays 1, and bits 31:11 and 9:6 stay 0.
- R11: Read data appears on `rdata` at the clock edge where `rd_en` is sampled high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | N_IRQ (16) | External interrupt request levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong pending or enable bit becomes visible at `irq_out` one edge after the fault. A read of offset 0xD0 or 0xC0 exposes it on the edge that samples `rd_en`. A pending bit that latched a disabled rise stays wrong until software clears it, so a single read after a masked rise followed by a late enable reveals it. Socket faults show within one cycle of a line change or a write, as a wrong bit 5 or a disturbed upper field in the socket word.

// File: rtl/irqb_pkg.sv
// Package: shared register offsets, field positions and write filters
// for the board interrupt aggregator. Assumes 8-bit byte offsets.
package irqb_pkg;

    // Offsets whose decode is part of the software contract
    localparam logic [7:0] OFF_ENABLE  = 8'hC0;
    localparam logic [7:0] OFF_PENDING = 8'hD0;
    localparam logic [7:0] OFF_SOCK0   = 8'hE0;
    localparam logic [7:0] OFF_SOCK1   = 8'hE4;

    // Scratch word offsets
    localparam int unsigned N_SCR = 8;
    localparam logic [7:0] SCR_OFF [N_SCR] = '{
        8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90
    };

    // Bits of enable/pending that software may hold at 1
    localparam logic [31:0] KEEP_MASK = 32'h000F_EEFF;

    // Socket word fields
    localparam int unsigned SOCK_WR_W    = 5;
    localparam int unsigned SOCK_CD_BIT  = 5;
    localparam int unsigned SOCK_RDY_BIT = 10;

endpackage

// File: rtl/irqb_edge.sv
// Module: irqb_edge
// Finds 0->1 transitions on a vector of level inputs by comparing each
// line with a registered copy of its previous value. Assumes the inputs
// are already synchronous to clk.
module irqb_edge #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    // Hold last cycle's input level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/irqb_intc.sv
// Module: irqb_intc
// Enable and pending registers plus the registered combined request.
// A rise sets a pending bit only when its enable bit is already 1.
// A software write to pending wins over rises on the same edge.
// Assumes N_IRQ < DATA_W.
module irqb_intc #(
    parameter int unsigned    N_IRQ  = 16,
    parameter int unsigned    DATA_W = 32,
    parameter logic [31:0]    KEEP   = 32'h000F_EEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  rise,
    input  logic              en_we,
    input  logic              pend_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] pend_q,
    output logic              irq_out
);

    localparam logic [DATA_W-1:0] KEEP_W = DATA_W'(KEEP);
    localparam int unsigned       PAD_W  = DATA_W - N_IRQ;

    logic [DATA_W-1:0] rise_w;
    logic [DATA_W-1:0] set_vec;

    assign rise_w  = {{PAD_W{1'b0}}, rise};
    assign set_vec = rise_w & en_q;

    // Enable register: filtered software write
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata & KEEP_W;
    end

    // Pending register: write has priority, otherwise accumulate enabled rises
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= '0;
        else if (pend_we) pend_q <= wdata & KEEP_W;
        else              pend_q <= pend_q | set_vec;
    end

    // Combined request, one cycle behind the registers
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(pend_q & en_q);
    end

endmodule

// File: rtl/irqb_socket.sv
// Module: irqb_socket
// One card-socket status word: writable low control field, card-absent
// bit tracking the inverse of a detect line, ready bit fixed at reset.
// Assumes CD_BIT >= WR_W so the tracked bit is outside the control field.
module irqb_socket #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WR_W    = 5,
    parameter int unsigned CD_BIT  = 5,
    parameter int unsigned RDY_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cd_in,
    output logic [DATA_W-1:0] stat_q
);

    localparam logic [DATA_W-1:0] RST_VAL =
        (DATA_W'(1) << RDY_BIT) | (DATA_W'(1) << CD_BIT);

    // Update control field on write, track detect line every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RST_VAL;
        end else begin
            if (we) stat_q[WR_W-1:0] <= wdata[WR_W-1:0];
            stat_q[CD_BIT] <= ~cd_in;
        end
    end

endmodule

// File: rtl/irqb_scratch.sv
// Module: irqb_scratch
// Plain read/write storage words at fixed offsets, with a combinational
// hit/value lookup for the read path. Offsets must be distinct.
module irqb_scratch
    import irqb_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_val
);

    logic [DATA_W-1:0] word_q [N_SCR];
    logic [N_SCR-1:0]  sel;

    for (genvar g = 0; g < N_SCR; g++) begin : g_word
        assign sel[g] = (addr == ADDR_W'(SCR_OFF[g]));

        // Store one scratch word on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)              word_q[g] <= '0;
            else if (wr_en && sel[g]) word_q[g] <= wdata;
        end
    end

    // Select the addressed word for reads
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < N_SCR; k++) begin
            if (sel[k]) rd_val = word_q[k];
        end
    end

    assign rd_hit = |sel;

endmodule

// File: rtl/irq_board_ctrl.sv
// Module: irq_board_ctrl (top)
// Board interrupt aggregator: edge detection, enable/pending control,
// two socket status words, scratch words and the register read mux.
// Assumes synchronous inputs and a single-cycle bus (no wait states).
module irq_board_ctrl
    import irqb_pkg::*;
#(
    parameter int unsigned N_IRQ   = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CD0_IRQ = 9,
    parameter int unsigned CD1_IRQ = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);

    localparam int unsigned N_SOCK = 2;
    localparam int unsigned CD_IDX [N_SOCK] = '{CD0_IRQ, CD1_IRQ};
    localparam logic [7:0]  SK_OFF [N_SOCK] = '{OFF_SOCK0, OFF_SOCK1};

    logic [N_IRQ-1:0]  rise;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] sock_q [N_SOCK];
    logic [DATA_W-1:0] sock0_q;
    logic [DATA_W-1:0] sock1_q;
    logic              hit_en;
    logic              hit_pend;
    logic [N_SOCK-1:0] hit_sock;
    logic              scr_hit;
    logic [DATA_W-1:0] scr_val;
    logic [DATA_W-1:0] rd_mux;

    assign hit_en   = (addr == ADDR_W'(OFF_ENABLE));
    assign hit_pend = (addr == ADDR_W'(OFF_PENDING));

    irqb_edge #(.N(N_IRQ)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (irq_in),
        .rise  (rise)
    );

    irqb_intc #(
        .N_IRQ  (N_IRQ),
        .DATA_W (DATA_W),
        .KEEP   (KEEP_MASK)
    ) u_intc (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .en_we   (wr_en && hit_en),
        .pend_we (wr_en && hit_pend),
        .wdata   (wdata),
        .en_q    (en_q),
        .pend_q  (pend_q),
        .irq_out (irq_out)
    );

    for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
        assign hit_sock[s] = (addr == ADDR_W'(SK_OFF[s]));

        irqb_socket #(
            .DATA_W  (DATA_W),
            .WR_W    (SOCK_WR_W),
            .CD_BIT  (SOCK_CD_BIT),
            .RDY_BIT (SOCK_RDY_BIT)
        ) u_sock (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_en && hit_sock[s]),
            .wdata  (wdata),
            .cd_in  (irq_in[CD_IDX[s]]),
            .stat_q (sock_q[s])
        );
    end

    assign sock0_q = sock_q[0];
    assign sock1_q = sock_q[1];

    irqb_scratch #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rd_hit (scr_hit),
        .rd_val (scr_val)
    );

    // Read mux: decoded register or zero for unmapped offsets
    always_comb begin
        if (hit_en)           rd_mux = en_q;
        else if (hit_pend)    rd_mux = pend_q;
        else if (hit_sock[0]) rd_mux = sock0_q;
        else if (hit_sock[1]) rd_mux = sock1_q;
        else if (scr_hit)     rd_mux = scr_val;
        else                  rd_mux = '0;
    end

    // Capture read data on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/irqb_chk.sv
// Module: irqb_chk
// Protocol checker bound into irq_board_ctrl. Observes ports and the
// enable, pending and socket registers; drives nothing.
module irqb_chk
    import irqb_pkg::*;
#(
    parameter int unsigned N_IRQ   = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CD0_IRQ = 9,
    parameter int unsigned CD1_IRQ = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_IRQ-1:0]  irq_in,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] pend_q,
    input logic [DATA_W-1:0] sock0_q,
    input logic [DATA_W-1:0] sock1_q,
    input logic              irq_out
);

    localparam logic [DATA_W-1:0] KEEP_W  = DATA_W'(KEEP_MASK);
    localparam logic [DATA_W-1:0] SK_FIX  = ~((DATA_W'(1) << (SOCK_WR_W + 1)) - DATA_W'(1));
    localparam logic [DATA_W-1:0] SK_RST  = DATA_W'(1) << SOCK_RDY_BIT;

    logic pend_wr;
    assign pend_wr = wr_en && (addr == ADDR_W'(OFF_PENDING));

    // R4
    filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~KEEP_W) == '0) && ((en_q & ~KEEP_W) == '0));

    // R8
    pend_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> (pend_q == ($past(wdata) & KEEP_W)));

    // R7
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(pend_q & en_q))));

    // R9
    cd0_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sock0_q[SOCK_CD_BIT] == !$past(irq_in[CD0_IRQ])));

    // R9
    cd1_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sock1_q[SOCK_CD_BIT] == !$past(irq_in[CD1_IRQ])));

    // R10
    sock_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sock0_q & SK_FIX) == SK_RST) && ((sock1_q & SK_FIX) == SK_RST));

    for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
        // R5
        masked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[i] && !en_q[i] && !pend_wr) |=> !pend_q[i]);

        // R6
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && !pend_wr) |=> pend_q[i]);
    end

endmodule

bind irq_board_ctrl irqb_chk #(
    .N_IRQ   (N_IRQ),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .CD0_IRQ (CD0_IRQ),
    .CD1_IRQ (CD1_IRQ)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .en_q    (en_q),
    .pend_q  (pend_q),
    .sock0_q (sock0_q),
    .sock1_q (sock1_q),
    .irq_out (irq_out)
);

// File: tb/test_irq_board_ctrl.sv
// Scoreboard bench: read tasks queue expected values, a monitor pops and
// compares them when the registered read data is valid.
module test_irq_board_ctrl;

    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    localparam logic [7:0] A_EN = 8'hC0, A_PD = 8'hD0, A_S0 = 8'hE0, A_S1 = 8'hE4;
    localparam logic [7:0] SCR [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_board_ctrl i_irq_board_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic lines(input logic [15:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    // Note when read data becomes valid
    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compare registered read data against the queue (R11)
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R11: actual=unexpected read expected=none");
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", {31'd0, irq_out}, 32'd0);
        rst_n = 1'b1;
        rd(A_EN, 32'h0, "R1 enable reset");
        rd(A_PD, 32'h0, "R1 pending reset");
        rd(SCR[0], 32'h0, "R1 scratch reset");
        rd(A_S0, 32'h420, "R1 socket0 reset");
        rd(A_S1, 32'h420, "R1 socket1 reset");

        // R2 scratch words
        for (int i = 0; i < 8; i++) wr(SCR[i], 32'h8000_0003 | (32'(i) << (3 * i + 4)));
        for (int i = 0; i < 8; i++) rd(SCR[i], 32'h8000_0003 | (32'(i) << (3 * i + 4)), "R2 scratch readback");

        // R3 unmapped offsets
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, 32'h0, "R3 unmapped read");
        rd(8'hFC, 32'h0, "R3 unmapped read high");
        wr(8'h14 ^ 8'h01, 32'h1234_5678);
        rd(SCR[1], 32'h8000_0003 | (32'd1 << 7), "R3 write ignored");

        // R4 filters
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, 32'h000F_EEFF, "R4 enable filter");
        wr(A_PD, 32'hFFFF_FFFF);
        rd(A_PD, 32'h000F_EEFF, "R4 pending filter");
        wr(A_PD, 32'h0);
        wr(A_EN, 32'h0);

        // R7 output timing
        wr(A_EN, 32'h1);
        wr(A_PD, 32'h1);
        check("R7 irq_out not yet", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        check("R7 irq_out one cycle later", {31'd0, irq_out}, 32'd1);
        wr(A_PD, 32'h0);
        @(negedge clk);
        check("R7 irq_out cleared", {31'd0, irq_out}, 32'd0);

        // R5 enable gating
        wr(A_EN, 32'h4);
        lines(16'h000C);
        rd(A_PD, 32'h4, "R5 only enabled rise latches");
        wr(A_EN, 32'hC);
        rd(A_PD, 32'h4, "R5 late enable does not latch");
        // R6 hold after fall
        lines(16'h0000);
        rd(A_PD, 32'h4, "R6 pending holds after fall");
        check("R6 irq_out held", {31'd0, irq_out}, 32'd1);
        wr(A_PD, 32'h0);
        @(negedge clk);
        check("R6 cleared by write", {31'd0, irq_out}, 32'd0);

        // R8 write wins on same edge
        wr(A_EN, 32'h41);
        @(negedge clk);
        irq_in = 16'h0040; wr_en = 1'b1; addr = A_PD; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_PD, 32'h1, "R8 write overrides rise");
        lines(16'h0000);
        wr(A_PD, 32'h0);

        // R9 card detect tracking
        lines(16'h0200);
        rd(A_S0, 32'h400, "R9 socket0 present");
        rd(A_S1, 32'h420, "R9 socket1 absent");
        lines(16'h2000);
        rd(A_S0, 32'h420, "R9 socket0 absent");
        rd(A_S1, 32'h400, "R9 socket1 present");

        // R10 socket write field
        wr(A_S0, 32'hFFFF_FFFF);
        rd(A_S0, 32'h43F, "R10 socket0 write limited");
        wr(A_S1, 32'hFFFF_FFD5);
        rd(A_S1, 32'h415, "R10 socket1 write limited");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11: actual=%0d pending reads expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule